// File: doc/BRIEF.md
# Booth-Recoded Carry-Save Signed Multiplier

This block multiplies two signed two's-complement operands of `WIDTH` bits and returns their full signed product of `2*WIDTH` bits. Each multiplier bit is examined together with the bit just below it. That pair is turned into a signed digit of -1, 0 or +1, and the digit is carried as two strobes: a nonzero flag and a negate flag. The multiplicand is negated once, and the result is shared by every row. Each row then selects zero, the multiplicand or its negation. The selection is sign-extended to the full product width and shifted by the row index.

A tree of carry-save adder rows reduces the `WIDTH` partial products level by level until exactly two operands remain. A parallel-prefix carry-lookahead adder sums those two operands. The low `2*WIDTH` bits of the sum are the product.

The path from operands to product is combinational. The parameter `OUT_REG` can add one output register stage, which is loaded only when `inValid` is high and which drives a matching `outValid` strobe.

Top module: `boothWallaceMul`

## Requirements
- R1: Each multiplier bit i forms the pair (bit i, bit i-1) and maps it to a digit: 00 and 11 give 0, 01 gives +1, 10 gives -1. The row for bit i contributes digit times multiplicand times 2^i.
- R2: The bit below the least significant multiplier bit is taken as 0. A multiplier of 1 therefore yields the sign-extended multiplicand.
- R3: A digit of -1 selects the two's-complement negation of the multiplicand, formed at the full product width. A multiplier of -1 yields minus the multiplicand, including +2^(WIDTH-1) for the most negative multiplicand.
- R4: For every pair of operands, the product equals the signed product truncated to 2*WIDTH bits. This includes (-2^(WIDTH-1)) squared, which is 2^(2*WIDTH-2).
- R5: With WIDTH=4, the operands 4'b0110 and 4'b1011 give the product 8'b11100010.
- R6: With OUT_REG=1, outValid is high in the cycle after a clock edge that sampled inValid high. At that point product holds the result for the operands sampled at that edge.
- R7: While rstN is low, outValid is 0 and product is 0 (OUT_REG=1).
- R8: With OUT_REG=1, an edge with inValid low leaves product unchanged, whatever the operands do.
- R9: With OUT_REG=0, product and outValid follow the operands and inValid within the same cycle, with no clock edge in between.
- R10: A zero operand on either side gives a zero product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operands on the inputs are valid |
| multiplicand | input | WIDTH | Signed multiplicand |
| multiplier | input | WIDTH | Signed multiplier, Booth recoded |
| outValid | output | 1 | Product is valid |
| product | output | 2*WIDTH | Signed product |

## Verification
Two functions can fall in the same cycle. In one, the output register loads a fresh product while the previous result is being presented. In the other, a gap cycle with `inValid` low must hold the old product while new random operands sit on the inputs. The 8-bit instance is driven with back-to-back valid operands mixed with random gap cycles. A scoreboard pairs each valid output with the expected signed product in order, and during every gap it compares the output against the last reported product. Corner operands such as the most negative value times -1, times itself and times 1 are placed directly next to gaps. A second, combinational 4-bit instance is swept exhaustively within the same cycle.

// File: rtl/boothWallacePkg.sv
package boothWallacePkg;

  typedef struct packed {
    logic nonZero;
    logic negate;
  } boothDigitT;

  function automatic int rowsAtLevel(input int startRows, input int level);
    int r;
    r = startRows;
    for (int l = 0; l < level; l++) begin
      if (r > 2) r = (r / 3) * 2 + (r % 3);
    end
    return r;
  endfunction

  function automatic int treeLevels(input int startRows);
    int r;
    int l;
    r = startRows;
    l = 0;
    while (r > 2) begin
      r = (r / 3) * 2 + (r % 3);
      l++;
    end
    return l;
  endfunction

endpackage

// File: rtl/boothRecoder.sv
module boothRecoder
  import boothWallacePkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]       multiplier,
  output boothDigitT [WIDTH-1:0] digits
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_digit
    logic lowerBit;
    if (i == 0) begin : g_first
      assign lowerBit = 1'b0;
    end else begin : g_rest
      assign lowerBit = multiplier[i-1];
    end
    assign digits[i].nonZero = multiplier[i] ^ lowerBit;
    assign digits[i].negate  = multiplier[i] & ~lowerBit;
  end

endmodule

// File: rtl/csaRow.sv
module csaRow #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] sum,
  output logic [W-1:0] carry
);

  assign sum = a ^ b ^ c;
  assign carry[0] = 1'b0;

  for (genvar k = 1; k < W; k++) begin : g_maj
    assign carry[k] = (a[k-1] & b[k-1]) | (a[k-1] & c[k-1]) | (b[k-1] & c[k-1]);
  end

endmodule

// File: rtl/prefixAdder.sv
module prefixAdder #(
  parameter int W = 16
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] sum
);

  localparam int STAGES = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0] genArr [STAGES+1];
  logic [W-1:0] propArr[STAGES+1];

  assign genArr[0]  = opA & opB;
  assign propArr[0] = opA ^ opB;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    localparam int DIST = 1 << s;
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i >= DIST) begin : g_merge
        assign genArr[s+1][i]  = genArr[s][i] | (propArr[s][i] & genArr[s][i-DIST]);
        assign propArr[s+1][i] = propArr[s][i] & propArr[s][i-DIST];
      end else begin : g_pass
        assign genArr[s+1][i]  = genArr[s][i];
        assign propArr[s+1][i] = propArr[s][i];
      end
    end
  end

  assign sum[0] = propArr[0][0];
  for (genvar i = 1; i < W; i++) begin : g_sum
    assign sum[i] = propArr[0][i] ^ genArr[STAGES][i-1];
  end

endmodule

// File: rtl/ppDatapath.sv
module ppDatapath
  import boothWallacePkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]       multiplicand,
  input  boothDigitT [WIDTH-1:0] digits,
  output logic [2*WIDTH-1:0]     product
);

  localparam int PW     = 2 * WIDTH;
  localparam int LEVELS = treeLevels(WIDTH);

  logic [PW-1:0] mdExt;
  logic [PW-1:0] mdNeg;
  logic [PW-1:0] rows [LEVELS+1][WIDTH];

  assign mdExt = {{WIDTH{multiplicand[WIDTH-1]}}, multiplicand};
  assign mdNeg = ~mdExt + {{(PW-1){1'b0}}, 1'b1};

  for (genvar i = 0; i < WIDTH; i++) begin : g_pp
    logic [PW-1:0] picked;
    assign picked = digits[i].nonZero ? (digits[i].negate ? mdNeg : mdExt) : '0;
    assign rows[0][i] = picked << i;
  end

  for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
    localparam int R   = rowsAtLevel(WIDTH, lv);
    localparam int T   = R / 3;
    localparam int REM = R % 3;
    localparam int NR  = T * 2 + REM;

    for (genvar g = 0; g < WIDTH / 3; g++) begin : g_csa
      if (g < T) begin : g_use
        csaRow #(.W(PW)) u_csa (
          .a    (rows[lv][3*g]),
          .b    (rows[lv][3*g+1]),
          .c    (rows[lv][3*g+2]),
          .sum  (rows[lv+1][2*g]),
          .carry(rows[lv+1][2*g+1])
        );
      end
    end

    for (genvar k = 0; k < 3; k++) begin : g_pass
      if (k < REM) begin : g_use
        assign rows[lv+1][2*T+k] = rows[lv][3*T+k];
      end
    end

    for (genvar u = 0; u < WIDTH; u++) begin : g_fill
      if (u >= NR) begin : g_zero
        assign rows[lv+1][u] = '0;
      end
    end
  end

  prefixAdder #(.W(PW)) u_add (
    .opA(rows[LEVELS][0]),
    .opB(rows[LEVELS][1]),
    .sum(product)
  );

endmodule

// File: rtl/boothWallaceMul.sv
module boothWallaceMul
  import boothWallacePkg::*;
#(
  parameter int WIDTH   = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic               outValid,
  output logic [2*WIDTH-1:0] product
);

  localparam int PW = 2 * WIDTH;

  boothDigitT [WIDTH-1:0] digits;
  logic [PW-1:0]          comboProduct;

  boothRecoder #(.WIDTH(WIDTH)) u_rec (
    .multiplier(multiplier),
    .digits    (digits)
  );

  ppDatapath #(.WIDTH(WIDTH)) u_dp (
    .multiplicand(multiplicand),
    .digits      (digits),
    .product     (comboProduct)
  );

  if (OUT_REG) begin : g_reg
    logic [PW-1:0] productQ;
    logic          validQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        productQ <= '0;
        validQ   <= 1'b0;
      end else begin
        validQ <= inValid;
        if (inValid) productQ <= comboProduct;
      end
    end
    assign product  = productQ;
    assign outValid = validQ;
  end else begin : g_comb
    assign product  = comboProduct;
    assign outValid = inValid;
  end

endmodule

// File: rtl/boothWallaceMulChk.sv
module boothWallaceMulChk #(
  parameter int WIDTH   = 8,
  parameter bit OUT_REG = 1'b1
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic [WIDTH-1:0]   multiplicand,
  input logic [WIDTH-1:0]   multiplier,
  input logic               outValid,
  input logic [2*WIDTH-1:0] product
);

  logic signed [2*WIDTH-1:0] refProd;
  assign refProd = $signed({{WIDTH{multiplicand[WIDTH-1]}}, multiplicand}) *
                   $signed({{WIDTH{multiplier[WIDTH-1]}}, multiplier});

  if (OUT_REG) begin : g_regChk
    // R4
    product_match_chk: assert property (@(posedge clk) disable iff (!rstN)
      inValid |=> (product == $past(refProd)));
    // R6
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
      inValid |=> outValid);
    // R6
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
      !inValid |=> !outValid);
    // R8
    hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      !inValid |=> $stable(product));
    // R2
    unit_mr_chk: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && multiplier == {{(WIDTH-1){1'b0}}, 1'b1}) |=>
      (product == {{WIDTH{$past(multiplicand[WIDTH-1])}}, $past(multiplicand)}));
    // R3
    neg_mr_chk: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && multiplier == {WIDTH{1'b1}}) |=>
      (product == ~{{WIDTH{$past(multiplicand[WIDTH-1])}}, $past(multiplicand)} + 1'b1));
    // R10
    zero_chk: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && (multiplier == '0 || multiplicand == '0)) |=> (product == '0));
    // R7
    reset_chk: assert property (@(posedge clk)
      !rstN |-> (!outValid && product == '0));
  end else begin : g_combChk
    // R9
    comb_match_chk: assert property (@(posedge clk) disable iff (!rstN)
      product == refProd);
    // R9
    comb_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
      outValid == inValid);
  end

endmodule

bind boothWallaceMul boothWallaceMulChk #(.WIDTH(WIDTH), .OUT_REG(OUT_REG)) u_chk (.*);

// File: tb/tb_boothWallaceMul.sv
module tb_boothWallaceMul;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int fails = 0;

  logic        v8 = 1'b0;
  logic [7:0]  a8 = '0;
  logic [7:0]  b8 = '0;
  logic        outV8;
  logic [15:0] p8;

  logic        v4 = 1'b0;
  logic [3:0]  a4 = '0;
  logic [3:0]  b4 = '0;
  logic        outV4;
  logic [7:0]  p4;

  typedef struct {
    logic [15:0] expected;
    string       tag;
  } scoreItemT;
  scoreItemT scoreQ[$];

  logic [15:0] lastP8 = '0;
  bit          seenOne = 1'b0;

  boothWallaceMul #(.WIDTH(8), .OUT_REG(1'b1)) dut (
    .clk(clk), .rstN(rstN), .inValid(v8), .multiplicand(a8), .multiplier(b8),
    .outValid(outV8), .product(p8)
  );

  boothWallaceMul #(.WIDTH(4), .OUT_REG(1'b0)) dutSmall (
    .clk(clk), .rstN(rstN), .inValid(v4), .multiplicand(a4), .multiplier(b4),
    .outValid(outV4), .product(p4)
  );

  task automatic checkVal(input bit ok, input string tag, input logic [31:0] act,
                          input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mul8(input logic [7:0] a, input logic [7:0] b);
    logic signed [15:0] r;
    r = $signed({{8{a[7]}}, a}) * $signed({{8{b[7]}}, b});
    return r;
  endfunction

  function automatic logic [7:0] mul4(input logic [3:0] a, input logic [3:0] b);
    logic signed [7:0] r;
    r = $signed({{4{a[3]}}, a}) * $signed({{4{b[3]}}, b});
    return r;
  endfunction

  task automatic drive8(input logic [7:0] a, input logic [7:0] b, input string tag);
    scoreItemT it;
    @(negedge clk);
    a8 = a;
    b8 = b;
    v8 = 1'b1;
    it.expected = mul8(a, b);
    it.tag = tag;
    scoreQ.push_back(it);
  endtask

  task automatic gap8();
    @(negedge clk);
    v8 = 1'b0;
    a8 = 8'($urandom);
    b8 = 8'($urandom);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Monitor: pops the scoreboard on each valid output, checks hold during gaps (R8)
  initial begin
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (outV8) begin
          if (scoreQ.size() == 0) begin
            checkVal(1'b0, "R6 unexpected valid", 32'(p8), 32'h0);
          end else begin
            scoreItemT it;
            it = scoreQ.pop_front();
            checkVal(p8 == it.expected, it.tag, 32'(p8), 32'(it.expected));
          end
          lastP8 = p8;
          seenOne = 1'b1;
        end else if (seenOne) begin
          checkVal(p8 == lastP8, "R8 hold", 32'(p8), 32'(lastP8));
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    checkVal(1'b0, "watchdog", 32'h0, 32'h1);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    checkVal(outV8 == 1'b0, "R7 outValid in reset", 32'(outV8), 32'h0);
    checkVal(p8 == 16'h0, "R7 product in reset", 32'(p8), 32'h0);
    rstN = 1'b1;

    // R2: lowest digit sees a zero below it
    drive8(8'd5, 8'd1, "R2 md*1");
    drive8(8'h80, 8'd1, "R2 min*1");
    gap8();
    // R3: negation, including the most negative multiplicand
    drive8(8'd7, 8'hFF, "R3 7*-1");
    drive8(8'h80, 8'hFF, "R3 min*-1");
    gap8();
    // R4: extremes
    drive8(8'h80, 8'h80, "R4 min*min");
    drive8(8'h7F, 8'h80, "R4 max*min");
    drive8(8'h7F, 8'h7F, "R4 max*max");
    gap8();
    gap8();
    // R10: zero operands
    drive8(8'h00, 8'h9C, "R10 zero md");
    drive8(8'h63, 8'h00, "R10 zero mr");
    // R1: isolated ones, runs of ones and alternating digits
    drive8(8'h2D, 8'h55, "R1 0x55");
    drive8(8'hD3, 8'hAA, "R1 0xAA");
    drive8(8'h39, 8'h0F, "R1 0x0F");
    drive8(8'hC1, 8'hF0, "R1 0xF0");
    drive8(8'h11, 8'h77, "R1 0x77");
    gap8();

    for (int n = 0; n < 3000; n++) begin
      drive8(8'($urandom), 8'($urandom), "R4 random");
      if (($urandom % 5) == 0) gap8();
    end
    gap8();
    gap8();
    gap8();
    checkVal(scoreQ.size() == 0, "R6 drained", 32'(scoreQ.size()), 32'h0);

    // R9 / R4 / R5: combinational 4-bit instance, exhaustive
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        @(negedge clk);
        a4 = 4'(a);
        b4 = 4'(b);
        v4 = 1'(b & 1);
        #1;
        checkVal(p4 == mul4(4'(a), 4'(b)), "R4 exhaustive 4-bit", 32'(p4),
                 32'(mul4(4'(a), 4'(b))));
        checkVal(outV4 == v4, "R9 valid follows", 32'(outV4), 32'(v4));
      end
    end

    @(negedge clk);
    a4 = 4'b0110;
    b4 = 4'b1011;
    v4 = 1'b1;
    #1;
    checkVal(p4 == 8'b11100010, "R5 worked example", 32'(p4), 32'hE2);
    a4 = 4'b1000;
    b4 = 4'b1000;
    #1;
    checkVal(p4 == 8'h40, "R9 same-cycle update", 32'(p4), 32'h40);

    repeat (2) @(negedge clk);
    finishRun();
  end

endmodule